// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller with Pin Edge Detection

This block collects interrupt events from four kinds of external pins and from on-chip peripherals. It latches them into sticky source flags and into per-vector pending bits, and arbitrates among the pending vectors. When an enabled vector wins while the master enable is set, the block reads a two-byte entry from a fixed table at the bottom of program memory. It then presents the CPU with a 14-bit start address and the two bank-enable bits to load. The CPU accepts the result with an acknowledge strobe.

Two of the vectors are shared by two sources. The sticky source flags stay set after servicing, so software can see which source fired and clear it with a write strobe. Test sources (a rising-edge test pin, a bank of four key-return pins and an on-chip test strobe) only set flags and never start a fetch. The selectable-edge pin can be routed through a sampling noise filter.

Top module: `intr_vector_ctrl`

## Requirements
- R1: Both rising and falling edges on `pinBoth` set `srcFlags[1]` and make vector line 0 pending. Line 0 is shared with the basic-interval-timer strobe `perReq[0]`, which sets `srcFlags[0]`.
- R2: An edge on `pinSel` sets `srcFlags[2]` and pends line 1 only when it matches the selected polarity: rising when `selEdgeRise`=1, falling when `selEdgeRise`=0.
- R3: With `filterEn`=1, `pinSel` is sampled once every `FILT_DIV` clocks, and a new level counts only after it is seen on two consecutive samples. A pulse shorter than `FILT_DIV` clocks is then ignored. With `filterEn`=0 a one-clock pulse is detected.
- R4: Only rising edges on `pinRise` set `srcFlags[3]` and pend line 2.
- R5: A rising edge on `pinTest` sets `testFlags[0]`, a falling edge on any of `keyPins` sets `testFlags[1]`, and a `perTest` strobe sets `testFlags[2]`. None of these starts a memory read.
- R6: The peripheral strobes `perReq[1]` (serial), `perReq[2]` (timer 0), `perReq[3]` (timer 1) and `perReq[4]` (timer 2) set `srcFlags[4]`, `[5]`, `[6]` and `[7]` and pend lines 3, 4, 5 and 5.
- R7: A pending line is serviced only when its `lineEn` bit and the master enable (set by `imeSet`, seen on `imeOut`) are both 1. Taking it clears that line's pending bit and clears the master enable.
- R8: Among serviceable lines, the lowest line number (lowest vector address) wins.
- R9: Servicing line i reads byte address 2+2i and then 3+2i. The first byte gives the memory-bank-enable flag in bit 7, the register-bank-enable flag in bit 6 and address bits 13:8 in bits 5:0. The second byte gives address bits 7:0.
- R10: `vecValid` rises after the second byte is captured. It stays high, with `vecAddr`, `vecMbe` and `vecRbe` stable and no memory read, until `cpuAck`.
- R11: After reset, all flags, `imeOut`, `vecValid` and `memRd` are 0. A `flagClr` bit clears the matching flag: bits 7:0 clear `srcFlags`, bits 10:8 clear `testFlags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinBoth | input | 1 | Both-edge interrupt pin |
| pinSel | input | 1 | Selectable-edge interrupt pin |
| pinRise | input | 1 | Rising-edge interrupt pin |
| pinTest | input | 1 | Rising-edge test pin |
| keyPins | input | 4 | Key-return pins, falling edge |
| selEdgeRise | input | 1 | Polarity for pinSel (1 rising) |
| filterEn | input | 1 | Route pinSel through the noise filter |
| perReq | input | 5 | Peripheral request strobes |
| perTest | input | 1 | On-chip test strobe |
| lineEn | input | 6 | Per-line enables |
| imeSet | input | 1 | Set master enable |
| flagClr | input | 11 | Flag clear strobes |
| memRd | output | 1 | Program memory read request |
| memAddr | output | 14 | Program memory byte address |
| memData | input | 8 | Read data, one clock after memRd |
| vecValid | output | 1 | Vector result valid |
| vecAddr | output | 14 | Start address |
| vecMbe | output | 1 | Memory-bank-enable value |
| vecRbe | output | 1 | Register-bank-enable value |
| cpuAck | input | 1 | CPU accepts the vector |
| srcFlags | output | 8 | Sticky source flags |
| testFlags | output | 3 | Sticky test flags |
| imeOut | output | 1 | Master enable state |

## Verification
A corrupted pending bit or arbitration result shows at the ports within one memory read. It appears as the wrong byte address on `memAddr` and a wrong `vecAddr` about four clocks after the request reaches the pending stage. A wrong edge-detector or filter state shows in `srcFlags` or `testFlags` a few clocks after the pin changes, or for the filter within two sample periods. A wrong fetch-state value shows at once as a read issued while `vecValid` is high, or as an unpaired byte read.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;
  localparam int NUM_LINES = 6;
  localparam int LINE_W    = 3;
  localparam int ADDR_W    = 14;
  localparam int BYTE_W    = 8;
  localparam int NUM_SRC   = 8;
  localparam int NUM_TEST  = 3;
  localparam int NUM_PER   = 5;
  localparam int NUM_KEY   = 4;
  localparam int NUM_PINS  = 4 + NUM_KEY;
  localparam int VEC_BASE  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_HI, ST_FETCH_LO, ST_CAP_LO, ST_HOLD
  } fetchState_t;

  typedef struct packed {
    logic take;
    logic capHi;
    logic capLo;
    logic loSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/intr_pin_sync.sv
module intr_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/intr_vec_dp.sv
module intr_vec_dp
  import intr_vec_pkg::*;
#(
  parameter int FILT_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinLvl,
  input  logic                selEdgeRise,
  input  logic                filterEn,
  input  logic [NUM_PER-1:0]  perReq,
  input  logic                perTest,
  input  logic [NUM_LINES-1:0] lineEn,
  input  logic                imeSet,
  input  logic [NUM_SRC+NUM_TEST-1:0] flagClr,
  input  logic [BYTE_W-1:0]   memData,
  input  ctrlStrobes_t        strb,
  output logic                anyReq,
  output logic [NUM_SRC-1:0]  srcFlags,
  output logic [NUM_TEST-1:0] testFlags,
  output logic                imeOut,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   vecAddr,
  output logic                vecMbe,
  output logic                vecRbe
);
  localparam int CNT_W = (FILT_DIV > 1) ? $clog2(FILT_DIV) : 1;
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(FILT_DIV - 1);
  localparam int EDGE_W = NUM_PINS;

  // noise filter on the selectable-edge pin
  logic [CNT_W-1:0] tickCnt;
  logic sampQ, filtQ, selLvl;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      sampQ   <= 1'b0;
      filtQ   <= 1'b0;
    end else if (tickCnt == TICK_LAST) begin
      tickCnt <= '0;
      sampQ   <= pinLvl[1];
      if (pinLvl[1] == sampQ) filtQ <= pinLvl[1];
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
  assign selLvl = filterEn ? filtQ : pinLvl[1];

  // edge detection
  logic [EDGE_W-1:0] edgeIn, prevQ, riseE, fallE;
  assign edgeIn = {pinLvl[NUM_PINS-1:2], selLvl, pinLvl[0]};
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= edgeIn;
  end
  assign riseE = edgeIn & ~prevQ;
  assign fallE = ~edgeIn & prevQ;

  logic [NUM_SRC-1:0]   srcHit;
  logic [NUM_TEST-1:0]  testHit;
  logic [NUM_LINES-1:0] lineHit;
  always_comb begin
    srcHit[0] = perReq[0];
    srcHit[1] = riseE[0] | fallE[0];
    srcHit[2] = selEdgeRise ? riseE[1] : fallE[1];
    srcHit[3] = riseE[2];
    srcHit[7:4] = perReq[4:1];
    testHit[0] = riseE[3];
    testHit[1] = |fallE[EDGE_W-1:4];
    testHit[2] = perTest;
    lineHit[0] = srcHit[0] | srcHit[1];
    lineHit[1] = srcHit[2];
    lineHit[2] = srcHit[3];
    lineHit[3] = srcHit[4];
    lineHit[4] = srcHit[5];
    lineHit[5] = srcHit[6] | srcHit[7];
  end

  // pending lines and arbitration
  logic [NUM_LINES-1:0] pendQ, ready;
  logic [LINE_W-1:0]    winIdx, lineSelQ;
  logic imeQ;
  assign ready = pendQ & lineEn;
  always_comb begin
    winIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (ready[i]) winIdx = LINE_W'(i);
  end
  assign anyReq = imeQ & (|ready);

  logic [NUM_SRC-1:0]  srcQ;
  logic [NUM_TEST-1:0] testQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= '0;
      srcQ     <= '0;
      testQ    <= '0;
      imeQ     <= 1'b0;
      lineSelQ <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++)
        pendQ[i] <= (pendQ[i] & ~(strb.take && winIdx == LINE_W'(i))) | lineHit[i];
      srcQ  <= (srcQ & ~flagClr[NUM_SRC-1:0]) | srcHit;
      testQ <= (testQ & ~flagClr[NUM_SRC+NUM_TEST-1:NUM_SRC]) | testHit;
      if (strb.take)  imeQ <= 1'b0;
      else if (imeSet) imeQ <= 1'b1;
      if (strb.take) lineSelQ <= winIdx;
    end
  end

  // vector table read and capture
  logic [ADDR_W-1:0] vecQ;
  logic mbeQ, rbeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ <= '0;
      mbeQ <= 1'b0;
      rbeQ <= 1'b0;
    end else begin
      if (strb.capHi) begin
        mbeQ <= memData[7];
        rbeQ <= memData[6];
        vecQ[ADDR_W-1:8] <= memData[ADDR_W-9:0];
      end
      if (strb.capLo) vecQ[7:0] <= memData;
    end
  end

  assign memAddr   = ADDR_W'(VEC_BASE) + ADDR_W'({lineSelQ, strb.loSel});
  assign srcFlags  = srcQ;
  assign testFlags = testQ;
  assign imeOut    = imeQ;
  assign vecAddr   = vecQ;
  assign vecMbe    = mbeQ;
  assign vecRbe    = rbeQ;
endmodule

// File: rtl/intr_vec_ctl.sv
module intr_vec_ctl
  import intr_vec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyReq,
  input  logic         cpuAck,
  output ctrlStrobes_t strb,
  output logic         memRd,
  output logic         vecValid
);
  fetchState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:     if (anyReq) stateD = ST_FETCH_HI;
      ST_FETCH_HI: stateD = ST_FETCH_LO;
      ST_FETCH_LO: stateD = ST_CAP_LO;
      ST_CAP_LO:   stateD = ST_HOLD;
      ST_HOLD:     if (cpuAck) stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.take  = (stateQ == ST_IDLE) && anyReq;
    strb.capHi = (stateQ == ST_FETCH_LO);
    strb.capLo = (stateQ == ST_CAP_LO);
    strb.loSel = (stateQ == ST_FETCH_LO);
  end
  assign memRd    = (stateQ == ST_FETCH_HI) || (stateQ == ST_FETCH_LO);
  assign vecValid = (stateQ == ST_HOLD);
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import intr_vec_pkg::*;
#(
  parameter int FILT_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinBoth,
  input  logic        pinSel,
  input  logic        pinRise,
  input  logic        pinTest,
  input  logic [3:0]  keyPins,
  input  logic        selEdgeRise,
  input  logic        filterEn,
  input  logic [4:0]  perReq,
  input  logic        perTest,
  input  logic [5:0]  lineEn,
  input  logic        imeSet,
  input  logic [10:0] flagClr,
  output logic        memRd,
  output logic [13:0] memAddr,
  input  logic [7:0]  memData,
  output logic        vecValid,
  output logic [13:0] vecAddr,
  output logic        vecMbe,
  output logic        vecRbe,
  input  logic        cpuAck,
  output logic [7:0]  srcFlags,
  output logic [2:0]  testFlags,
  output logic        imeOut
);
  logic [NUM_PINS-1:0] pinLvl;
  ctrlStrobes_t strb;
  logic anyReq;

  intr_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({keyPins, pinTest, pinRise, pinSel, pinBoth}),
    .dout(pinLvl)
  );

  intr_vec_dp #(.FILT_DIV(FILT_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .pinLvl(pinLvl), .selEdgeRise(selEdgeRise),
    .filterEn(filterEn), .perReq(perReq), .perTest(perTest), .lineEn(lineEn),
    .imeSet(imeSet), .flagClr(flagClr), .memData(memData), .strb(strb),
    .anyReq(anyReq), .srcFlags(srcFlags), .testFlags(testFlags), .imeOut(imeOut),
    .memAddr(memAddr), .vecAddr(vecAddr), .vecMbe(vecMbe), .vecRbe(vecRbe)
  );

  intr_vec_ctl u_ctl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .cpuAck(cpuAck),
    .strb(strb), .memRd(memRd), .vecValid(vecValid)
  );
endmodule

// File: rtl/intr_vector_ctrl_chk.sv
module intr_vector_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memRd,
  input logic [13:0] memAddr,
  input logic        vecValid,
  input logic [13:0] vecAddr,
  input logic        vecMbe,
  input logic        vecRbe,
  input logic        cpuAck,
  input logic        imeOut
);
  AST_TAKE_DROPS_IME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRd) |-> !imeOut); // R7
  AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memAddr[0]) |=> (memRd && memAddr == $past(memAddr) + 14'd1)); // R9
  AST_FETCH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr >= 14'd2 && memAddr <= 14'd13)); // R9
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !cpuAck) |=> (vecValid && $stable(vecAddr) && $stable(vecMbe) && $stable(vecRbe))); // R10
  AST_NO_RD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> !memRd); // R10
endmodule

bind intr_vector_ctrl intr_vector_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memAddr(memAddr), .vecValid(vecValid),
  .vecAddr(vecAddr), .vecMbe(vecMbe), .vecRbe(vecRbe), .cpuAck(cpuAck), .imeOut(imeOut)
);

// File: tb/intr_vector_ctrl_tb.sv
module intr_vector_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinBoth = 0, pinSel = 0, pinRise = 0, pinTest = 0;
  logic [3:0] keyPins = 4'hF;
  logic selEdgeRise = 1, filterEn = 0;
  logic [4:0] perReq = '0;
  logic perTest = 0;
  logic [5:0] lineEn = '0;
  logic imeSet = 0;
  logic [10:0] flagClr = '0;
  logic memRd;
  logic [13:0] memAddr;
  logic [7:0] memData;
  logic vecValid, vecMbe, vecRbe, imeOut;
  logic [13:0] vecAddr;
  logic cpuAck = 0;
  logic [7:0] srcFlags;
  logic [2:0] testFlags;

  int checks = 0, errors = 0;
  int rdCnt = 0;
  int rdLog [4];

  always #5 clk = ~clk;

  intr_vector_ctrl u_dut (.*);

  function automatic logic [13:0] vecOf(input int i);
    return 14'h1000 + 14'(i) * 14'h0123;
  endfunction

  function automatic logic [7:0] romByte(input logic [13:0] a);
    int i;
    logic [13:0] v;
    if (a < 2 || a > 13) return 8'hFF;
    i = (int'(a) - 2) / 2;
    v = vecOf(i);
    if (!a[0]) return {i[0], i[1], v[13:8]};
    return v[7:0];
  endfunction

  always_ff @(posedge clk) if (memRd) memData <= romByte(memAddr);

  always @(negedge clk) if (memRd) begin
    if (rdCnt < 4) rdLog[rdCnt] = int'(memAddr);
    rdCnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clearAll();
    flagClr = '1; cyc(1); flagClr = '0;
  endtask

  task automatic setIme();
    imeSet = 1; cyc(1); imeSet = 0;
  endtask

  task automatic pulsePer(input logic [4:0] p);
    perReq = p; cyc(1); perReq = '0;
  endtask

  task automatic waitValid(input int n, output bit got);
    got = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (vecValid) begin got = 1; break; end
    end
  endtask

  task automatic ackVec();
    cpuAck = 1; cyc(1); cpuAck = 0;
  endtask

  task automatic drain();
    bit got;
    lineEn = '1;
    for (int k = 0; k < 8; k++) begin
      setIme();
      waitValid(12, got);
      if (!got) break;
      ackVec();
    end
  endtask

  // {perReq[4:0], expFlags[7:0], expLine[2:0]}
  localparam logic [15:0] VEC_TBL [6] = '{
    {5'b00001, 8'h01, 3'd0},
    {5'b00010, 8'h10, 3'd3},
    {5'b00100, 8'h20, 3'd4},
    {5'b01000, 8'h40, 3'd5},
    {5'b10000, 8'h80, 3'd5},
    {5'b11110, 8'hF0, 3'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    cyc(3);
    rstN = 1;
    cyc(4);
    // R11 reset state
    chk(srcFlags == 0 && testFlags == 0, "R11 flags after reset", {srcFlags, testFlags}, 0);
    chk(!imeOut && !vecValid && !memRd, "R11 ime/valid/rd after reset", {imeOut, vecValid, memRd}, 0);

    // Table walk: R6 flags and sharing, R8 priority, R9 fetch layout
    lineEn = '1;
    foreach (VEC_TBL[e]) begin
      logic [4:0] p;
      logic [7:0] ef;
      int ln;
      p = VEC_TBL[e][15:11];
      ef = VEC_TBL[e][10:3];
      ln = int'(VEC_TBL[e][2:0]);
      clearAll();
      setIme();
      rdCnt = 0;
      pulsePer(p);
      waitValid(20, got);
      chk(got, "R7 vector presented", int'(got), 1);
      chk(vecAddr == vecOf(ln), "R8/R9 start address", vecAddr, vecOf(ln));
      chk(vecMbe == ln[0] && vecRbe == ln[1], "R9 bank flags", {vecMbe, vecRbe}, {ln[0], ln[1]});
      chk(rdCnt == 2 && rdLog[0] == 2 + 2 * ln && rdLog[1] == 3 + 2 * ln,
          "R9 read order", rdLog[0], 2 + 2 * ln);
      chk(srcFlags == ef, "R6 source flags", srcFlags, ef);
      cyc(3);
      chk(vecValid && vecAddr == vecOf(ln), "R10 held until ack", vecAddr, vecOf(ln));
      ackVec();
      chk(!vecValid, "R10 dropped after ack", vecValid, 0);
      drain();
    end

    // R1 both-edge pin
    lineEn = '0;
    clearAll();
    pinBoth = 1; cyc(6);
    chk(srcFlags[1], "R1 rising edge", srcFlags, 2);
    clearAll();
    pinBoth = 0; cyc(6);
    chk(srcFlags[1], "R1 falling edge", srcFlags, 2);

    // R2 selectable edge
    clearAll();
    selEdgeRise = 1; pinSel = 1; cyc(6);
    chk(srcFlags[2], "R2 rising selected, rise", srcFlags, 4);
    clearAll();
    pinSel = 0; cyc(6);
    chk(!srcFlags[2], "R2 rising selected, fall ignored", srcFlags, 0);
    selEdgeRise = 0; cyc(2);
    pinSel = 1; cyc(6);
    chk(!srcFlags[2], "R2 falling selected, rise ignored", srcFlags, 0);
    pinSel = 0; cyc(6);
    chk(srcFlags[2], "R2 falling selected, fall", srcFlags, 4);

    // R4 rising-only pin
    clearAll();
    pinRise = 1; cyc(6);
    chk(srcFlags[3], "R4 rising edge", srcFlags, 8);
    clearAll();
    pinRise = 0; cyc(6);
    chk(!srcFlags[3], "R4 falling ignored", srcFlags, 0);

    // R3 noise filter
    selEdgeRise = 1; filterEn = 1; cyc(10);
    clearAll();
    pinSel = 1; cyc(2); pinSel = 0; cyc(20);
    chk(!srcFlags[2], "R3 short pulse filtered", srcFlags, 0);
    pinSel = 1; cyc(20);
    chk(srcFlags[2], "R3 stable level accepted", srcFlags, 4);
    pinSel = 0; cyc(20);
    filterEn = 0; cyc(4);
    clearAll();
    pinSel = 1; cyc(1); pinSel = 0; cyc(6);
    chk(srcFlags[2], "R3 unfiltered one-clock pulse seen", srcFlags, 4);

    // R5 test sources never vector
    drain();
    clearAll();
    lineEn = '1;
    setIme();
    rdCnt = 0;
    pinTest = 1; keyPins = 4'b1011; perTest = 1; cyc(1); perTest = 0;
    cyc(15);
    chk(testFlags == 3'b111, "R5 test flags set", testFlags, 7);
    chk(rdCnt == 0 && !vecValid, "R5 no fetch from test sources", rdCnt, 0);
    keyPins = 4'hF; pinTest = 0; cyc(6);
    flagClr = 11'b010_0000_0000; cyc(1); flagClr = '0;
    chk(testFlags == 3'b101, "R11 clear single test flag", testFlags, 5);

    // R7 enable gating and ime clearing
    clearAll();
    lineEn = '0;
    pulsePer(5'b00010);
    waitValid(10, got);
    chk(!got, "R7 disabled line not serviced", int'(got), 0);
    lineEn[3] = 1;
    waitValid(10, got);
    chk(got && vecAddr == vecOf(3), "R7 enabled line serviced", vecAddr, vecOf(3));
    chk(!imeOut, "R7 take clears master enable", imeOut, 0);
    ackVec();
    pulsePer(5'b00010);
    waitValid(10, got);
    chk(!got, "R7 master enable off blocks", int'(got), 0);
    setIme();
    waitValid(10, got);
    chk(got && vecAddr == vecOf(3), "R7 serviced after ime set", vecAddr, vecOf(3));
    ackVec();
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule